// File: doc/BRIEF.md
# Sampled Supply Monitor Controller

This block is the slow-clock digital controller around an analog undervoltage comparator on the main I/O supply rail. The comparator is modelled as a single input bit, `cmp_low` (1 = supply below threshold). The controller drives the comparator enable and its threshold code. The enable is either held on permanently or pulsed for one slow-clock period in every 32, 256 or 2048 periods, which lowers the comparator's average power.

The controller captures the comparator output only in an enabled period, holds that sample otherwise, and treats a change of the sample from "OK" to "low" as an undervoltage event. An event always sets an interrupt-event flag. It also sets a reset flag when reset generation is enabled, and a wake flag when wake-up from backup mode is enabled. These flags drive `irq` (gated by the interrupt enable), `core_rst_req` and `wake_req` as levels until software clears them.

A simple register port accesses the registers. It is always ready, so it applies no back-pressure: every cycle with `acc_valid` high is one complete access. Reads return `rd_data` combinationally in the same cycle. The clear-on-read side effect takes place at the closing clock edge.

Top module: `supply_mon_ctrl`

Register map (address: fields):
- 0 CFG: [1:0] sampling mode, [7:4] threshold code, [8] reset enable
- 1 BKWAKE: [0] wake enable
- 2 INTEN: [0] interrupt enable
- 3 WAKESTAT: [0] wake flag, [1] reset flag (reading clears both)
- 4 INTSTAT: [0] event flag (reading clears it)
- 5 STATUS: [0] wake flag, [1] reset flag, [2] held comparator sample, [3] event flag (read-only, reading clears nothing)

## Requirements
- R1: After reset, the sampling mode is 0, every flag is 0, `irq`, `core_rst_req` and `wake_req` are 0, `cmp_en` is 1 and STATUS reads 0.
- R2: In sampling mode 0 (continuous), `cmp_en` stays 1 and `cmp_low` is captured on every clock edge.
- R3: Sampling modes 1, 2 and 3 pulse `cmp_en` high for exactly one cycle in every 32, 256 or 2048 cycles respectively. A write to CFG that changes the mode restarts the period count, so the first pulse comes N-1 cycles after the write edge.
- R4: In a sampled mode, `cmp_low` is captured only at the edge that ends the enabled cycle. Between windows the held sample does not change, and activity on `cmp_low` outside a window causes no event.
- R5: An event is raised only when the captured sample changes from 0 to 1. A sample that stays 1 raises no further event.
- R6: `cmp_thresh` always equals CFG[7:4].
- R7: An event with the reset enable (CFG[8]) set sets the reset flag, and `core_rst_req` is 1 while that flag is set. With the enable clear, the reset flag stays 0.
- R8: An event with the wake enable (BKWAKE[0]) set sets the wake flag, and `wake_req` is 1 while that flag is set. With the enable clear, the wake flag stays 0.
- R9: Every event sets the event flag, and `irq` is 1 whenever the event flag and INTEN[0] are both 1. The flag becomes visible one edge after the capturing edge's inputs were presented.
- R10: A read of WAKESTAT returns the wake and reset flags and clears them at that edge, so both the WAKESTAT copy and the STATUS copy clear. Reading STATUS clears no flag.
- R11: A read of INTSTAT returns the event flag and clears it at that edge.
- R12: When an event and a clearing read of the same flag fall on the same edge, the flag ends up set.
- R13: STATUS[2] shows the held comparator sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data (combinational) |
| cmp_low | input | 1 | Comparator output, 1 = undervoltage |
| cmp_en | output | 1 | Comparator enable |
| cmp_thresh | output | 4 | Comparator threshold code |
| core_rst_req | output | 1 | Core-domain reset request (level) |
| wake_req | output | 1 | Backup-mode wake-up request (level) |
| irq | output | 1 | Interrupt request (level) |

## Verification
An undervoltage event and a clear-on-read access to the flag it sets can land on the same clock edge. The bench provokes this in continuous mode. In a single cycle it raises `cmp_low` and issues an INTSTAT read. It expects the read data to show the flag as 0 and `irq` to be 1 after the edge. A scoreboard queue holds the cycle at which each interrupt rise should appear, so every rise, including this one, is matched against a predicted cycle. Any rise that was not predicted counts as a failure.

// File: rtl/smon_pkg.sv
package smon_pkg;

  localparam int ADDR_W = 3;
  localparam int NFLAG  = 3;

  localparam int FL_WAKE = 0;
  localparam int FL_RST  = 1;
  localparam int FL_EV   = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG      = 3'd0,
    A_BKWAKE   = 3'd1,
    A_INTEN    = 3'd2,
    A_WAKESTAT = 3'd3,
    A_INTSTAT  = 3'd4,
    A_STATUS   = 3'd5
  } smon_addr_e;

  typedef enum logic [1:0] {
    SM_CONT = 2'd0,
    SM_P1   = 2'd1,
    SM_P2   = 2'd2,
    SM_P3   = 2'd3
  } smp_mode_e;

endpackage

// File: rtl/smon_sampler.sv
module smon_sampler
  import smon_pkg::*;
#(
  parameter int PER1 = 32,
  parameter int PER2 = 256,
  parameter int PER3 = 2048
) (
  input  logic      clk,
  input  logic      rst_n,
  input  smp_mode_e mode,
  input  logic      mode_chg,
  input  logic      cmp_low,
  output logic      cmp_en,
  output logic      sample,
  output logic      detect
);
  localparam int CNT_W = $clog2(PER3);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    case (mode)
      SM_P1:   last = CNT_W'(PER1 - 1);
      SM_P2:   last = CNT_W'(PER2 - 1);
      SM_P3:   last = CNT_W'(PER3 - 1);
      default: last = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (mode_chg || mode == SM_CONT) cnt_q <= '0;
    else if (cnt_q == last)               cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  // The enable window doubles as the capture strobe
  assign cmp_en = (mode == SM_CONT) || (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sample <= 1'b0;
    else if (cmp_en) sample <= cmp_low;
  end

  assign detect = cmp_en & cmp_low & ~sample;

endmodule

// File: rtl/smon_flag.sv
module smon_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // set dominates a same-edge clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end
endmodule

// File: rtl/smon_regs.sv
module smon_regs
  import smon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [NFLAG-1:0]  flags,
  input  logic              sample,
  output smp_mode_e         mode,
  output logic              mode_chg,
  output logic [THR_W-1:0]  thresh,
  output logic              rst_en,
  output logic              wake_en,
  output logic              irq_en,
  output logic              clr_wakestat,
  output logic              clr_intstat,
  output logic [DATA_W-1:0] rd_data
);
  localparam int THR_LSB   = 4;
  localparam int RSTEN_BIT = THR_LSB + THR_W;

  logic wr_cfg, wr_bk, wr_ie, rd_any;
  logic unused_wdata;

  assign unused_wdata = ^acc_wdata;
  assign rd_any  = acc_valid & ~acc_write;
  assign wr_cfg  = acc_valid & acc_write & (acc_addr == A_CFG);
  assign wr_bk   = acc_valid & acc_write & (acc_addr == A_BKWAKE);
  assign wr_ie   = acc_valid & acc_write & (acc_addr == A_INTEN);
  assign mode_chg = wr_cfg & (acc_wdata[1:0] != mode);

  assign clr_wakestat = rd_any & (acc_addr == A_WAKESTAT);
  assign clr_intstat  = rd_any & (acc_addr == A_INTSTAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= SM_CONT;
      thresh  <= '0;
      rst_en  <= 1'b0;
      wake_en <= 1'b0;
      irq_en  <= 1'b0;
    end else begin
      if (wr_cfg) begin
        mode   <= smp_mode_e'(acc_wdata[1:0]);
        thresh <= acc_wdata[THR_LSB +: THR_W];
        rst_en <= acc_wdata[RSTEN_BIT];
      end
      if (wr_bk) wake_en <= acc_wdata[0];
      if (wr_ie) irq_en  <= acc_wdata[0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (acc_addr)
      A_CFG: begin
        rd_data[1:0]                = mode;
        rd_data[THR_LSB +: THR_W]   = thresh;
        rd_data[RSTEN_BIT]          = rst_en;
      end
      A_BKWAKE:   rd_data[0] = wake_en;
      A_INTEN:    rd_data[0] = irq_en;
      A_WAKESTAT: rd_data[1:0] = {flags[FL_RST], flags[FL_WAKE]};
      A_INTSTAT:  rd_data[0] = flags[FL_EV];
      A_STATUS:   rd_data[3:0] = {flags[FL_EV], sample, flags[FL_RST], flags[FL_WAKE]};
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/supply_mon_ctrl.sv
module supply_mon_ctrl
  import smon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int THR_W  = 4,
  parameter int PER1   = 32,
  parameter int PER2   = 256,
  parameter int PER3   = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cmp_low,
  output logic              cmp_en,
  output logic [THR_W-1:0]  cmp_thresh,
  output logic              core_rst_req,
  output logic              wake_req,
  output logic              irq
);
  smp_mode_e        mode_w;
  logic             mode_chg_w, rst_en_w, wake_en_w, irq_en_w;
  logic             clr_wakestat_w, clr_intstat_w;
  logic             sample_w, detect_w;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

  smon_regs #(.DATA_W(DATA_W), .THR_W(THR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .flags(flag_q), .sample(sample_w),
    .mode(mode_w), .mode_chg(mode_chg_w), .thresh(cmp_thresh),
    .rst_en(rst_en_w), .wake_en(wake_en_w), .irq_en(irq_en_w),
    .clr_wakestat(clr_wakestat_w), .clr_intstat(clr_intstat_w),
    .rd_data(rd_data)
  );

  smon_sampler #(.PER1(PER1), .PER2(PER2), .PER3(PER3)) u_smp (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .mode_chg(mode_chg_w),
    .cmp_low(cmp_low), .cmp_en(cmp_en), .sample(sample_w), .detect(detect_w)
  );

  assign flag_set[FL_WAKE] = detect_w & wake_en_w;
  assign flag_set[FL_RST]  = detect_w & rst_en_w;
  assign flag_set[FL_EV]   = detect_w;
  assign flag_clr[FL_WAKE] = clr_wakestat_w;
  assign flag_clr[FL_RST]  = clr_wakestat_w;
  assign flag_clr[FL_EV]   = clr_intstat_w;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    smon_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[g]), .clr(flag_clr[g]), .q(flag_q[g])
    );
  end

  assign core_rst_req = flag_q[FL_RST];
  assign wake_req     = flag_q[FL_WAKE];
  assign irq          = flag_q[FL_EV] & irq_en_w;

endmodule

// File: rtl/smon_chk.sv
module smon_chk
  import smon_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_write,
  input logic [2:0] acc_addr,
  input logic       cmp_en,
  input logic       core_rst_req,
  input logic       wake_req,
  input logic [1:0] smp_mode,
  input logic       sample,
  input logic       ev_flag
);
  logic rd_wakestat;
  assign rd_wakestat = acc_valid & ~acc_write & (acc_addr == A_WAKESTAT);

  a_r3_single_window: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_mode != 2'd0 && cmp_en) |=> (!cmp_en || smp_mode == 2'd0));

  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_mode != 2'd0 && !cmp_en) |=> $stable(sample));

  a_r5_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_flag) |-> $rose(sample));

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample) |-> ev_flag);

  a_r7_rst_held: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_req && !rd_wakestat) |=> core_rst_req);

  a_r8_wake_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !rd_wakestat) |=> wake_req);

endmodule

bind supply_mon_ctrl smon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .cmp_en(cmp_en), .core_rst_req(core_rst_req),
  .wake_req(wake_req), .smp_mode(mode_w), .sample(sample_w),
  .ev_flag(flag_q[2])
);

// File: tb/test_supply_mon_ctrl.sv
`timescale 1ns/1ps
module test_supply_mon_ctrl;
  import smon_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        cmp_low = 1'b0;
  logic        cmp_en, core_rst_req, wake_req, irq;
  logic [3:0]  cmp_thresh;

  supply_mon_ctrl i_supply_mon_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .cmp_low(cmp_low), .cmp_en(cmp_en), .cmp_thresh(cmp_thresh),
    .core_rst_req(core_rst_req), .wake_req(wake_req), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0, n_bad = 0;
  int  exp_q[$];
  logic irq_prev = 1'b0;
  bit  done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every irq rise must match a predicted cycle (R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && !irq_prev) begin
        if (exp_q.size() == 0) check("R9 unpredicted irq rise", 32'd1, 32'd0);
        else                   check("R9 irq rise cycle", cyc, exp_q.pop_front());
      end
      irq_prev <= irq;
    end
  end

  function automatic logic [31:0] cfg_word(input int m, input bit ren);
    return 32'(m) | (32'hA << 4) | (32'(ren) << 8);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic measure(input int m, input int per);
    int k;
    wr(A_CFG, cfg_word(m, 1'b1));
    k = 0;
    while (!cmp_en && k < 5000) begin @(negedge clk); k++; end
    check("R3 first window after mode change", k, per - 1);
    @(negedge clk);
    check("R3 window is one cycle", cmp_en, 1'b0);
    k = 1;
    while (!cmp_en && k < 5000) begin @(negedge clk); k++; end
    check("R3 window period", k, per);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cmp_en after reset", cmp_en, 1'b1);
    check("R1 irq after reset", irq, 1'b0);
    check("R1 core_rst_req after reset", core_rst_req, 1'b0);
    check("R1 wake_req after reset", wake_req, 1'b0);
    rd(A_STATUS, d);
    check("R1 STATUS after reset", d, 32'h0);

    // R6 threshold passthrough, enables on
    wr(A_CFG, cfg_word(0, 1'b1));
    check("R6 threshold code", cmp_thresh, 4'hA);
    wr(A_BKWAKE, 32'h1);
    wr(A_INTEN, 32'h1);
    check("R2 continuous enable", cmp_en, 1'b1);

    // R2 R7 R8 R9 continuous detection
    @(negedge clk);
    cmp_low = 1'b1; exp_q.push_back(cyc + 1);
    @(negedge clk);
    check("R9 irq after event", irq, 1'b1);
    check("R7 core_rst_req after event", core_rst_req, 1'b1);
    check("R8 wake_req after event", wake_req, 1'b1);
    rd(A_STATUS, d);
    check("R13 STATUS mirrors with sample", d, 32'hF);
    rd(A_STATUS, d);
    check("R10 STATUS read clears nothing", d, 32'hF);
    rd(A_WAKESTAT, d);
    check("R10 WAKESTAT value", d, 32'h3);
    check("R10 core_rst_req cleared", core_rst_req, 1'b0);
    check("R10 wake_req cleared", wake_req, 1'b0);
    rd(A_STATUS, d);
    check("R10 STATUS copies cleared", d, 32'hC);
    rd(A_INTSTAT, d);
    check("R11 INTSTAT value", d, 32'h1);
    check("R11 irq cleared", irq, 1'b0);
    repeat (5) @(negedge clk);
    check("R5 sustained low no retrigger", irq, 1'b0);

    // R7 R8 R9 with enables cleared
    wr(A_BKWAKE, 32'h0);
    wr(A_CFG, cfg_word(0, 1'b0));
    wr(A_INTEN, 32'h0);
    cmp_low = 1'b0;
    repeat (2) @(negedge clk);
    cmp_low = 1'b1;
    @(negedge clk);
    check("R7 reset flag stays 0 when disabled", core_rst_req, 1'b0);
    check("R8 wake flag stays 0 when disabled", wake_req, 1'b0);
    check("R9 irq gated off", irq, 1'b0);
    rd(A_INTSTAT, d);
    check("R9 event recorded without irq enable", d, 32'h1);
    wr(A_INTEN, 32'h1);
    check("R11 flag stays cleared", irq, 1'b0);

    // R12 event and clearing read on the same edge
    cmp_low = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    cmp_low = 1'b1; exp_q.push_back(cyc + 1);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = A_INTSTAT;
    #1 d = rd_data;
    check("R12 read data before set", d, 32'h0);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R12 set wins over clear", irq, 1'b1);
    rd(A_INTSTAT, d);
    cmp_low = 1'b0;
    repeat (2) @(negedge clk);

    // R3 R4 sampled every 32
    wr(A_CFG, cfg_word(1, 1'b1));
    begin
      int e;
      e = cyc;
      for (int k = 1; k <= 32; k++) begin
        @(negedge clk);
        if (k == 10) cmp_low = 1'b1;
        if (k == 20) cmp_low = 1'b0;
        if (k == 24) check("R4 no event outside window", irq, 1'b0);
        if (k == 25) begin cmp_low = 1'b1; exp_q.push_back(e + 32); end
        if (k == 30) check("R3 no window before count end", cmp_en, 1'b0);
        if (k == 31) check("R3 window at count end", cmp_en, 1'b1);
      end
    end
    check("R4 captured at window end", irq, 1'b1);
    rd(A_INTSTAT, d);
    repeat (40) @(negedge clk);
    check("R5 sampled low no retrigger", irq, 1'b0);
    cmp_low = 1'b0;
    rd(A_STATUS, d);
    check("R4 held sample between windows", d[2], 1'b1);

    measure(2, 256);
    measure(3, 2048);
    measure(1, 32);
    wr(A_CFG, cfg_word(0, 1'b1));
    check("R2 continuous after sampled", cmp_en, 1'b1);
    repeat (2) @(negedge clk);
    check("R5 no event on recovery", irq, 1'b0);
    check("R9 all predicted rises seen", exp_q.size(), 0);

    done = 1;
    finish_run();
  end

endmodule